// File: doc/BRIEF.md
# Bank-Switching Wait-State Controller

This block sits between a processor core's memory access sequencer and the external memory bus. For every external access it decides whether one idle cycle must come first. A stall is needed when the access lands in a different memory bank from the previous access in the same space. A stall is also needed when the bus turns from one address space to the other, from data to program or from a program read to a data read. The sequencer drives the access on its access inputs. If `wait_req` is high in that cycle, the sequencer holds the same access for one more cycle, and in that cycle the access is accepted without a further wait.

A 16-bit control word, reached through a memory-mapped write and read port at address 0x29, sets the run-time behaviour. It holds a 4-bit mask over the top four address bits, which sets the bank size between 4K and 64K words. It also holds the turnaround enable for a program read followed by a data read, two bus-keeper enables, and a request to take the external bus off. While the bus-off request is set, a lock output tells the core to block writes to its memory-map mode bits and its host-mode bit.

Top module: `bsw_wait_ctrl`

## Requirements
- R1: After reset, a read of the control word returns 0xF800 (mask 1111 in bits 15:12, turnaround enable in bit 11, zeros elsewhere), and `wait_req`, `host_hold_en`, `data_hold_en`, `ext_bus_off` and `mode_lock` are all 0.
- R2: The first access accepted after reset never raises `wait_req`.
- R3: Two consecutive accesses in the same space request one wait when their upper four address bits differ in any position selected by the mask. When the delayed access is presented again in the next cycle, it is accepted with `wait_req` low.
- R4: An address bit 15-k, for k in 0..3, takes part in the bank comparison only when mask bit 15-k is 1. Mask 0000 makes the 64K space a single bank, and mask 1111 gives 4K-word banks.
- R5: An access to program space (`acc_prog`=1) that follows an accepted data-space access always requests one wait, whether either access reads or writes.
- R6: A data read that follows a program read requests one wait when bit 11 is 1 and none when it is 0. A data access that follows a program write requests no wait for a space change.
- R7: A write with address 0x29 stores bits 15:11 and 2:0. Bits 10:3 read as 0. Writes to any other address leave the control word unchanged. A read returns its data on `mmr_rdata` one clock edge after the request, and the read value is 0 for any address other than 0x29.
- R8: `host_hold_en` follows bit 2 and `data_hold_en` follows bit 1 from the clock edge that takes the write.
- R9: `mode_lock` follows bit 0 from the clock edge that takes the write. `ext_bus_off` rises on the edge after bit 0 is 1 in a cycle with no valid access, so an access in progress completes first. `ext_bus_off` falls on the edge after bit 0 has been cleared.
- R10: Only an accepted access (valid with `wait_req` low) updates the stored bank bits and space. A control-word write affects the decision for the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mmr_wr | input | 1 | Register write strobe |
| mmr_rd | input | 1 | Register read strobe |
| mmr_addr | input | 8 | Register address |
| mmr_wdata | input | 16 | Register write data |
| mmr_rdata | output | 16 | Registered read data |
| acc_valid | input | 1 | External access presented |
| acc_addr | input | 16 | Access word address |
| acc_prog | input | 1 | 1 = program space, 0 = data space |
| acc_write | input | 1 | 1 = write, 0 = read |
| wait_req | output | 1 | Insert one idle cycle before this access |
| host_hold_en | output | 1 | Host-port bus keeper enable |
| data_hold_en | output | 1 | Data bus keeper enable |
| ext_bus_off | output | 1 | External bus interface disabled |
| mode_lock | output | 1 | Block writes to memory-map and host mode bits |

## Verification
`wait_req` is a same-cycle answer to the presented access. The bench drives each access after a falling edge and samples `wait_req` shortly afterwards, before the next rising edge. The bench then compares it with a function of the stored history and the control word. The keeper enables and `mode_lock` are sampled at the falling edge after the write edge, and `mmr_rdata` at the falling edge after the read edge. `ext_bus_off` is checked at each falling edge across the two-edge sequence of request, idle cycle and assertion. The random phase models the sequencer: it re-presents every delayed access, so history updates on accepted accesses only.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  localparam int REG_W = 16;
  localparam int CMP_W = 4;

  typedef struct packed {
    logic [CMP_W-1:0] bank_mask;
    logic             pd_turn;
    logic             host_keep;
    logic             data_keep;
    logic             ext_off;
  } bsw_cfg_t;

  function automatic logic [REG_W-1:0] cfg_word(bsw_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[REG_W-1 -: CMP_W] = c.bank_mask;
    w[REG_W-CMP_W-1]    = c.pd_turn;
    w[2]                = c.host_keep;
    w[1]                = c.data_keep;
    w[0]                = c.ext_off;
    return w;
  endfunction
endpackage

// File: rtl/bsw_ctrl_reg.sv
module bsw_ctrl_reg
  import bsw_pkg::*;
#(
  parameter int              MMR_AW    = 8,
  parameter logic [MMR_AW-1:0] CTRL_ADDR = 8'h29
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [MMR_AW-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output bsw_cfg_t          cfg,
  output logic [REG_W-1:0]  rdata
);
  logic hit;
  logic unused_rsvd;
  assign hit         = (addr == CTRL_ADDR);
  assign unused_rsvd = ^wdata[REG_W-CMP_W-2:3];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.bank_mask <= '1;
      cfg.pd_turn   <= 1'b1;
      cfg.host_keep <= 1'b0;
      cfg.data_keep <= 1'b0;
      cfg.ext_off   <= 1'b0;
    end else if (wr_en && hit) begin
      cfg.bank_mask <= wdata[REG_W-1 -: CMP_W];
      cfg.pd_turn   <= wdata[REG_W-CMP_W-1];
      cfg.host_keep <= wdata[2];
      cfg.data_keep <= wdata[1];
      cfg.ext_off   <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                rdata <= '0;
    else if (rd_en && hit)  rdata <= cfg_word(cfg);
    else                    rdata <= '0;
  end

  // R7: control word only changes on a write to its own address
  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && hit) |=> $stable(cfg));
  // R7: reserved field always reads zero
  assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (rst)
    rdata[REG_W-CMP_W-2:3] == '0);
endmodule

// File: rtl/bsw_wait_gen.sv
module bsw_wait_gen
  import bsw_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMP_W-1:0] bank_mask,
  input  logic             pd_turn,
  input  logic             acc_valid,
  input  logic [AW-1:0]    acc_addr,
  input  logic             acc_prog,
  input  logic             acc_write,
  output logic             wait_req
);
  localparam int TOP_LSB = AW - CMP_W;

  logic             hist_vld;
  logic [CMP_W-1:0] last_top;
  logic             last_prog;
  logic             last_write;
  logic             waited;
  logic [CMP_W-1:0] cur_top;
  logic             bank_cross;
  logic             to_prog;
  logic             read_turn;
  logic             accept;

  assign cur_top    = acc_addr[AW-1:TOP_LSB];
  assign bank_cross = (acc_prog == last_prog) && (((cur_top ^ last_top) & bank_mask) != '0);
  assign to_prog    = !last_prog && acc_prog;
  assign read_turn  = pd_turn && last_prog && !last_write && !acc_prog && !acc_write;
  assign wait_req   = acc_valid && hist_vld && !waited && (bank_cross || to_prog || read_turn);
  assign accept     = acc_valid && !wait_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_vld   <= 1'b0;
      last_top   <= '0;
      last_prog  <= 1'b0;
      last_write <= 1'b0;
      waited     <= 1'b0;
    end else begin
      waited <= wait_req;
      if (accept) begin
        hist_vld   <= 1'b1;
        last_top   <= cur_top;
        last_prog  <= acc_prog;
        last_write <= acc_write;
      end
    end
  end

  // R3: a wait is one cycle long, never two back to back
  assert_single_wait_R3: assert property (@(posedge clk) disable iff (rst)
    wait_req |=> !wait_req);
  // R2: no wait without a previously accepted access
  assert_first_free_R2: assert property (@(posedge clk) disable iff (rst)
    wait_req |-> (acc_valid && hist_vld));
  // R10: a delayed access leaves the history untouched
  assert_hist_kept_R10: assert property (@(posedge clk) disable iff (rst)
    wait_req |=> ($stable(last_top) && $stable(last_prog) && $stable(last_write)));
endmodule

// File: rtl/bsw_wait_ctrl.sv
module bsw_wait_ctrl
  import bsw_pkg::*;
#(
  parameter int              AW        = 16,
  parameter int              MMR_AW    = 8,
  parameter logic [MMR_AW-1:0] CTRL_ADDR = 8'h29
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mmr_wr,
  input  logic              mmr_rd,
  input  logic [MMR_AW-1:0] mmr_addr,
  input  logic [REG_W-1:0]  mmr_wdata,
  output logic [REG_W-1:0]  mmr_rdata,
  input  logic              acc_valid,
  input  logic [AW-1:0]     acc_addr,
  input  logic              acc_prog,
  input  logic              acc_write,
  output logic              wait_req,
  output logic              host_hold_en,
  output logic              data_hold_en,
  output logic              ext_bus_off,
  output logic              mode_lock
);
  bsw_cfg_t cfg;
  logic     off_q;

  bsw_ctrl_reg #(.MMR_AW(MMR_AW), .CTRL_ADDR(CTRL_ADDR)) u_reg (
    .clk(clk), .rst(rst), .wr_en(mmr_wr), .rd_en(mmr_rd), .addr(mmr_addr),
    .wdata(mmr_wdata), .cfg(cfg), .rdata(mmr_rdata)
  );

  bsw_wait_gen #(.AW(AW)) u_wait (
    .clk(clk), .rst(rst), .bank_mask(cfg.bank_mask), .pd_turn(cfg.pd_turn),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_prog(acc_prog),
    .acc_write(acc_write), .wait_req(wait_req)
  );

  always_ff @(posedge clk) begin
    if (rst) off_q <= 1'b0;
    else     off_q <= cfg.ext_off && (off_q || !acc_valid);
  end

  assign ext_bus_off  = off_q;
  assign mode_lock    = cfg.ext_off;
  assign host_hold_en = cfg.host_keep;
  assign data_hold_en = cfg.data_keep;

  // R9: the bus goes off only after a cycle with no access in flight
  assert_off_after_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_bus_off) |-> $past(!acc_valid));
  // R9: bus off implies the lock was already requested one cycle before
  assert_off_needs_lock_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_bus_off) |-> $past(mode_lock));
endmodule

// File: tb/bsw_wait_ctrl_tb.sv
module bsw_wait_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        mmr_wr, mmr_rd;
  logic [7:0]  mmr_addr;
  logic [15:0] mmr_wdata, mmr_rdata;
  logic        acc_valid;
  logic [15:0] acc_addr;
  logic        acc_prog, acc_write;
  logic        wait_req, host_hold_en, data_hold_en, ext_bus_off, mode_lock;

  int total = 0;
  int bad   = 0;

  logic [15:0] m_ctrl;
  logic        m_hv;
  logic [3:0]  m_top;
  logic        m_prog, m_wr;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsw_wait_ctrl u_dut (
    .clk(clk), .rst(rst), .mmr_wr(mmr_wr), .mmr_rd(mmr_rd), .mmr_addr(mmr_addr),
    .mmr_wdata(mmr_wdata), .mmr_rdata(mmr_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_prog(acc_prog), .acc_write(acc_write),
    .wait_req(wait_req), .host_hold_en(host_hold_en), .data_hold_en(data_hold_en),
    .ext_bus_off(ext_bus_off), .mode_lock(mode_lock)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_wait(input logic [15:0] a, input logic p, input logic w);
    if (!m_hv) return 1'b0;
    if (p == m_prog) return ((a[15:12] ^ m_top) & m_ctrl[15:12]) != 4'b0;
    if (!m_prog && p) return 1'b1;
    if (m_prog && !m_wr && !p && !w) return m_ctrl[11];
    return 1'b0;
  endfunction

  function automatic string tag_of(input logic p, input logic w);
    if (!m_hv) return "R2";
    if (p == m_prog) return (m_ctrl[15:12] == 4'hF) ? "R3" : "R4";
    if (p) return "R5";
    return (w || m_wr) ? "R6 (write)" : "R6";
  endfunction

  task automatic access(input logic [15:0] a, input logic p, input logic w);
    logic e;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_prog = p; acc_write = w;
    #1;
    e = exp_wait(a, p, w);
    check(tag_of(p, w), {15'd0, wait_req}, {15'd0, e});
    @(posedge clk);
    if (e) begin
      @(negedge clk);
      #1;
      check("R3 re-present R10", {15'd0, wait_req}, 16'd0);
      @(posedge clk);
    end
    m_hv = 1'b1; m_top = a[15:12]; m_prog = p; m_wr = w;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] ad, input logic [15:0] d);
    @(negedge clk);
    acc_valid = 1'b0;
    mmr_wr = 1'b1; mmr_addr = ad; mmr_wdata = d;
    @(posedge clk);
    if (ad == 8'h29) m_ctrl = d & 16'hF807;
    @(negedge clk);
    mmr_wr = 1'b0;
    check("R8 host keeper", {15'd0, host_hold_en}, {15'd0, m_ctrl[2]});
    check("R8 data keeper", {15'd0, data_hold_en}, {15'd0, m_ctrl[1]});
    check("R9 lock", {15'd0, mode_lock}, {15'd0, m_ctrl[0]});
  endtask

  task automatic reg_read(input logic [7:0] ad, input string req);
    @(negedge clk);
    acc_valid = 1'b0;
    mmr_rd = 1'b1; mmr_addr = ad;
    @(posedge clk);
    @(negedge clk);
    mmr_rd = 1'b0;
    check(req, mmr_rdata, (ad == 8'h29) ? m_ctrl : 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd12345;
    void'($urandom(seed));
    rst = 1'b1; mmr_wr = 0; mmr_rd = 0; mmr_addr = 0; mmr_wdata = 0;
    acc_valid = 0; acc_addr = 0; acc_prog = 0; acc_write = 0;
    m_ctrl = 16'hF800; m_hv = 0; m_top = 0; m_prog = 0; m_wr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    check("R1 wait", {15'd0, wait_req}, 16'd0);
    check("R1 keepers", {14'd0, host_hold_en, data_hold_en}, 16'd0);
    check("R1 bus off", {14'd0, ext_bus_off, mode_lock}, 16'd0);
    reg_read(8'h29, "R1 reset word");

    // directed corners
    access(16'h1000, 0, 0);             // R2 first access
    access(16'h2000, 0, 0);             // R3 bank cross
    access(16'h2FFF, 0, 0);             // R3 same bank
    access(16'h3000, 1, 0);             // R5 data -> program
    access(16'h3000, 0, 0);             // R6 prog read -> data read
    access(16'h4000, 1, 1);             // R5 data -> program write
    access(16'h4000, 0, 0);             // R6 after program write
    reg_write(8'h29, 16'h0000);         // R10 mask 0, turnaround off
    access(16'h9000, 1, 0);             // R5 still waits
    access(16'h1000, 0, 0);             // R6 off
    access(16'hF000, 0, 0);             // R4 single bank
    reg_write(8'h29, 16'h8000);
    access(16'h7000, 0, 0);             // R4 bit15 differs
    access(16'h0123, 0, 0);             // R4 bit15 same
    reg_write(8'h29, 16'hFFFE);
    reg_read(8'h29, "R7 reserved masked");
    reg_write(8'h28, 16'h0000);
    reg_read(8'h29, "R7 other address ignored");
    reg_read(8'h28, "R7 other address reads zero");

    // R9 bus-off sequencing
    access(16'h0123, 0, 0);
    @(negedge clk);
    acc_valid = 1'b1; mmr_wr = 1'b1; mmr_addr = 8'h29; mmr_wdata = 16'hF801;
    @(posedge clk);
    m_ctrl = 16'hF801;
    @(negedge clk);
    mmr_wr = 1'b0;
    check("R9 lock set", {15'd0, mode_lock}, 16'd1);
    check("R9 busy keeps bus", {15'd0, ext_bus_off}, 16'd0);
    @(posedge clk);
    @(negedge clk);
    check("R9 still busy", {15'd0, ext_bus_off}, 16'd0);
    acc_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R9 bus off", {15'd0, ext_bus_off}, 16'd1);
    mmr_wr = 1'b1; mmr_wdata = 16'hF800;
    @(posedge clk);
    m_ctrl = 16'hF800;
    @(negedge clk);
    mmr_wr = 1'b0;
    check("R9 lock clear", {15'd0, mode_lock}, 16'd0);
    check("R9 off lags", {15'd0, ext_bus_off}, 16'd1);
    @(posedge clk);
    @(negedge clk);
    check("R9 bus back", {15'd0, ext_bus_off}, 16'd0);

    // random phase
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 29);
      if (r == 0) begin
        reg_write(($urandom_range(0, 3) == 0) ? 8'h2A : 8'h29, 16'($urandom));
      end else if (r == 1) begin
        reg_read(8'h29, "R7 random read");
      end else if (r == 2) begin
        idle();
      end else begin
        logic [15:0] a;
        a = {2'b00, 2'($urandom_range(0, 3)), 12'($urandom)};
        if ($urandom_range(0, 1) == 1) a[15] = 1'b1;
        access(a, 1'($urandom), 1'($urandom));
      end
    end
    idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule